// File: doc/BRIEF.md
# Load/Store Address Unit

This unit forms the memory address for one load or store and the updated value of its base register. A request supplies a base register value and its 4-bit selector, the address of the current instruction, an unsigned 12-bit immediate, an index register value with a left-shift amount, and mode bits. The mode bits choose pre- or post-indexing, writeback, immediate or register offset, and add or subtract. The result appears on registered outputs one clock after the request strobe.

If the request's condition input is low, the unit still reports a valid result but raises neither the access strobe nor the writeback strobe. When selector 15 is the base, the program counter is used as the base, with a read-ahead of 8 bytes, and no writeback is allowed.

Top module: `ls_addr_gen`

## Requirements
- R1: After reset, all strobes are low and `ea`, `wb_data` and `wb_sel` are zero. `out_valid` is high exactly in the cycle after a cycle with `req` high.
- R2: With `pre_idx`=1 and `wb_en`=0, `ea` is base plus offset and `wb_strobe` stays low.
- R3: With `pre_idx`=1 and `wb_en`=1, `ea` is base plus offset, `wb_data` equals `ea`, and `wb_strobe` is high.
- R4: With `pre_idx`=0 (post-indexing), `ea` is the unmodified base, `wb_data` is base plus offset, and `wb_strobe` is high whatever the value of `wb_en`.
- R5: With `use_reg`=0, the offset is `imm` zero-extended to 32 bits.
- R6: With `use_reg`=1, the offset is `idx_val` shifted left by `shamt` bits. A `shamt` of 0 gives the plain index value.
- R7: With `up`=0, the offset is subtracted instead of added. All address arithmetic wraps modulo 2^32.
- R8: When `base_sel` is 15, the base is `pc_val`+8 and `wb_strobe` stays low.
- R9: When a request has `cond_ok`=0, `acc_en` and `wb_strobe` stay low in the result cycle, while `out_valid` still rises.
- R10: In a cycle after `req` is low, `ea`, `wb_data` and `wb_sel` keep their previous values, and `acc_en` and `wb_strobe` are low.
- R11: `wb_sel` carries the `base_sel` value of the request that produced the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe |
| cond_ok | input | 1 | Condition passed; when low the request makes no access |
| pre_idx | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| wb_en | input | 1 | Writeback request for pre-indexed mode |
| use_reg | input | 1 | 1 = register offset, 0 = immediate offset |
| up | input | 1 | 1 = add offset, 0 = subtract offset |
| base_sel | input | 4 | Base register selector; 15 selects the program counter |
| base_val | input | 32 | Base register value |
| pc_val | input | 32 | Address of the current instruction |
| imm | input | 12 | Unsigned immediate offset |
| idx_val | input | 32 | Index register value |
| shamt | input | 5 | Left shift applied to the index register |
| out_valid | output | 1 | Result valid |
| acc_en | output | 1 | Memory access enable |
| ea | output | 32 | Effective address |
| wb_strobe | output | 1 | Base register writeback enable |
| wb_data | output | 32 | New base register value |
| wb_sel | output | 4 | Register to write back |

## Verification
Two outputs can fire in the same result cycle: the access strobe and the writeback strobe, which happens for any passing post-indexed or pre-indexed-with-writeback request. The bench provokes this overlap and then breaks it in three ways. It clears the condition input, it selects register 15 as the base, and it uses pre-indexing without writeback. In the overlap cases the address and the writeback value must differ as the mode requires. A behavioural reference compares all outputs on every clock, across directed cases and a run of random mode words.

// File: rtl/ls_addr_gen.sv
`timescale 1ns/1ps
module ls_addr_gen #(
  parameter int AW = 32,
  parameter int OFFW = 12,
  parameter int SELW = 4,
  parameter int SHW = 5,
  parameter int PC_AHEAD = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            cond_ok,
  input  logic            pre_idx,
  input  logic            wb_en,
  input  logic            use_reg,
  input  logic            up,
  input  logic [SELW-1:0] base_sel,
  input  logic [AW-1:0]   base_val,
  input  logic [AW-1:0]   pc_val,
  input  logic [OFFW-1:0] imm,
  input  logic [AW-1:0]   idx_val,
  input  logic [SHW-1:0]  shamt,
  output logic            out_valid,
  output logic            acc_en,
  output logic [AW-1:0]   ea,
  output logic            wb_strobe,
  output logic [AW-1:0]   wb_data,
  output logic [SELW-1:0] wb_sel
);
  localparam logic [SELW-1:0] PC_SEL = '1;

  logic          is_pc;
  logic [AW-1:0] base_eff, offset, moved;
  logic          wants_wb;

  assign is_pc    = (base_sel == PC_SEL);
  assign base_eff = is_pc ? pc_val + AW'(PC_AHEAD) : base_val;
  assign offset   = use_reg ? (idx_val << shamt) : AW'(imm);
  assign moved    = up ? base_eff + offset : base_eff - offset;
  assign wants_wb = !pre_idx || wb_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      acc_en    <= 1'b0;
      wb_strobe <= 1'b0;
      ea        <= '0;
      wb_data   <= '0;
      wb_sel    <= '0;
    end else begin
      out_valid <= req;
      acc_en    <= req && cond_ok;
      wb_strobe <= req && cond_ok && wants_wb && !is_pc;
      if (req) begin
        ea      <= pre_idx ? moved : base_eff;
        wb_data <= moved;
        wb_sel  <= base_sel;
      end
    end
  end
endmodule

module ls_addr_gen_chk #(
  parameter int AW = 32,
  parameter int SELW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req,
  input logic            cond_ok,
  input logic            pre_idx,
  input logic [SELW-1:0] base_sel,
  input logic            out_valid,
  input logic            acc_en,
  input logic            wb_strobe,
  input logic [AW-1:0]   ea,
  input logic [AW-1:0]   wb_data
);
  // R1
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> out_valid);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (!out_valid && !acc_en && !wb_strobe && $stable(ea) && $stable(wb_data)));
  // R9
  cond_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !cond_ok) |=> (!acc_en && !wb_strobe));
  // R8
  pc_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && base_sel == '1) |=> !wb_strobe);
  // R4
  post_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && cond_ok && !pre_idx && base_sel != '1) |=> wb_strobe);
  // R9
  wb_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_strobe |-> (acc_en && out_valid));
endmodule

bind ls_addr_gen ls_addr_gen_chk #(.AW(AW), .SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .cond_ok(cond_ok), .pre_idx(pre_idx),
  .base_sel(base_sel), .out_valid(out_valid), .acc_en(acc_en),
  .wb_strobe(wb_strobe), .ea(ea), .wb_data(wb_data)
);

// File: tb/test_ls_addr_gen.sv
`timescale 1ns/1ps
module test_ls_addr_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, cond_ok = 0, pre_idx = 0, wb_en = 0, use_reg = 0, up = 0;
  logic [3:0]  base_sel = 0;
  logic [31:0] base_val = 0, pc_val = 0, idx_val = 0;
  logic [11:0] imm = 0;
  logic [4:0]  shamt = 0;
  logic out_valid, acc_en, wb_strobe;
  logic [31:0] ea, wb_data;
  logic [3:0]  wb_sel;

  int compared = 0, mismatched = 0;
  string cur_req = "R1";
  bit done = 0;

  logic e_valid = 0, e_acc = 0, e_wb = 0;
  logic [31:0] e_ea = 0, e_wbd = 0;
  logic [3:0]  e_sel = 0;

  always #2 clk = ~clk;

  ls_addr_gen i_ls_addr_gen (
    .clk(clk), .rst_n(rst_n), .req(req), .cond_ok(cond_ok), .pre_idx(pre_idx),
    .wb_en(wb_en), .use_reg(use_reg), .up(up), .base_sel(base_sel),
    .base_val(base_val), .pc_val(pc_val), .imm(imm), .idx_val(idx_val),
    .shamt(shamt), .out_valid(out_valid), .acc_en(acc_en), .ea(ea),
    .wb_strobe(wb_strobe), .wb_data(wb_data), .wb_sel(wb_sel)
  );

  // behavioural reference
  always @(posedge clk) begin
    longint b, o, s;
    if (!rst_n) begin
      e_valid = 0; e_acc = 0; e_wb = 0; e_ea = 0; e_wbd = 0; e_sel = 0;
    end else begin
      b = (base_sel == 4'd15) ? longint'(pc_val) + 8 : longint'(base_val);
      o = use_reg ? longint'(idx_val) * (longint'(1) << shamt) : longint'(imm);
      s = up ? b + o : b - o;
      e_valid = req;
      e_acc = req && cond_ok;
      e_wb = req && cond_ok && (!pre_idx || wb_en) && base_sel != 4'd15;
      if (req) begin
        e_ea  = pre_idx ? s[31:0] : b[31:0];
        e_wbd = s[31:0];
        e_sel = base_sel;
      end
    end
  end

  task automatic cmp1(string nm, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, nm, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    cmp1("out_valid", {31'd0, out_valid}, {31'd0, e_valid});
    cmp1("acc_en", {31'd0, acc_en}, {31'd0, e_acc});
    cmp1("wb_strobe", {31'd0, wb_strobe}, {31'd0, e_wb});
    cmp1("ea", ea, e_ea);
    cmp1("wb_data", wb_data, e_wbd);
    cmp1("wb_sel", {28'd0, wb_sel}, {28'd0, e_sel});
  end

  task automatic issue(string tag, bit c, bit p, bit w, bit r, bit u,
                       logic [3:0] sel, logic [31:0] bv, logic [11:0] im,
                       logic [31:0] iv, logic [4:0] sh);
    @(negedge clk); #1;
    cur_req = tag;
    req = 1; cond_ok = c; pre_idx = p; wb_en = w; use_reg = r; up = u;
    base_sel = sel; base_val = bv; imm = im; idx_val = iv; shamt = sh;
    pc_val = 32'h0000_8000;
  endtask

  task automatic idle(string tag);
    @(negedge clk); #1;
    cur_req = tag;
    req = 0; base_val = 32'hDEAD_BEEF; imm = 12'hABC;
  endtask

  initial begin
    #400000;
    $display("FAIL watchdog: actual running expected finished");
    mismatched++;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    issue("R2", 1, 1, 0, 0, 1, 4'd1, 32'h1000, 12'd20, 0, 0);
    issue("R3", 1, 1, 1, 0, 1, 4'd1, 32'h1000, 12'd4, 0, 0);
    issue("R4", 1, 0, 0, 0, 1, 4'd2, 32'h2000, 12'd4, 0, 0);
    issue("R4", 1, 0, 1, 0, 1, 4'd2, 32'h2004, 12'd4, 0, 0);
    issue("R5", 1, 1, 0, 0, 1, 4'd3, 32'h0, 12'hFFF, 0, 0);
    issue("R6", 1, 1, 0, 1, 1, 4'd3, 32'h100, 0, 32'd5, 5'd2);
    issue("R6", 1, 0, 0, 1, 1, 4'd4, 32'h100, 0, 32'd7, 5'd0);
    issue("R7", 1, 1, 1, 0, 0, 4'd5, 32'h10, 12'h20, 0, 0);
    issue("R7", 1, 1, 0, 0, 1, 4'd5, 32'hFFFF_FFFC, 12'h8, 0, 0);
    issue("R8", 1, 1, 1, 0, 1, 4'd15, 32'h1234, 12'd24, 0, 0);
    issue("R8", 1, 0, 0, 0, 1, 4'd15, 32'h1234, 12'd4, 0, 0);
    issue("R9", 0, 0, 1, 0, 1, 4'd6, 32'h3000, 12'd4, 0, 0);
    issue("R9", 0, 1, 1, 1, 1, 4'd6, 32'h3000, 0, 32'd3, 5'd3);
    idle("R10");
    idle("R10");
    issue("R11", 1, 1, 0, 0, 1, 4'd13, 32'h4000, 12'd1, 0, 0);
    idle("R10");
    for (int i = 0; i < 300; i++) begin
      bit gap;
      issue("R7", $urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 1),
            $urandom_range(0, 1), $urandom_range(0, 1), 4'($urandom),
            $urandom, 12'($urandom), $urandom, 5'($urandom));
      gap = ($urandom_range(0, 4) == 0);
      if (gap) idle("R10");
    end
    idle("R10");
    @(negedge clk); #1 rst_n = 0; cur_req = "R1";
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule